// File: doc/BRIEF.md
# Multiple-Ramp Column Conversion Sequencer

This block sequences a two-pass column conversion and keeps the per-column results. One shared counter first runs a short coarse pass. During that pass every column is tied to ramp zero. Each column keeps the counter value at which its comparator first switches, and that small code then picks one of eight ramps for the column. A longer fine pass follows, in which all eight ramps move together. Each column keeps a second counter value from this pass. The analog side (comparators, ramp switches, ramp generators) sits outside the block: comparator outputs arrive here as one digital bit per column, and the block returns ramp-select addresses and counter values to drive the ramps.

Finished results go into one of two banks, so readout of one conversion can run during the next one. The fine pass lasts 128 counts for equal-slope ramps or 64 counts for companding ramps. A third mode drops the coarse pass and runs a single 1024-count pass on ramp zero. In that mode each column acts as a plain 10-bit single-slope converter.

Top module: `mramp_seq`

## Requirements
- R1: A `start_i` pulse seen while idle begins a coarse pass on the next cycle. The coarse pass lasts NRAMP (8) cycles, with `count_o` running 0 to 7. A `start_i` pulse while `busy_o` is high has no effect.
- R2: While `force_zero_o` is high, every column's ramp-select field in `ramp_sel_o` is 0. `force_zero_o` is high for the whole coarse pass and for the whole single-slope pass.
- R3: In the coarse pass, a column stores the `count_o` value of the first cycle in which its comparator input is 1 after being 0 in the cycle before. Later rising edges in the same pass are ignored. A column with no rising edge stores 7.
- R4: After the coarse pass, the fine pass starts at once with `count_o` from 0. The pass lasts 128 cycles for mode 0 (equal slope) and 64 cycles for mode 1 (companding). Field c of `ramp_sel_o` (bits c*3+2..c*3) holds column c's stored coarse code and stays unchanged through the pass.
- R5: In the fine pass, a column stores the counter value at its first rising comparator edge and ignores later edges. A column with no rising edge stores 255.
- R6: Mode 2 or 3 (`mode_i[1]`=1) skips the coarse pass and runs one 1024-cycle pass with `force_zero_o` high and `phase_fine_o` high. The stored coarse code is 0. A column with no rising edge stores 1023.
- R7: `done_o` is high for exactly the one cycle after the last cycle of the final pass, and `busy_o` is low in that cycle. After reset, both are low and all phase outputs are low.
- R8: From the `done_o` cycle on, `rd_coarse_o` and `rd_fine_o` show the results of the conversion that just finished, for the column selected by `rd_col_i`. They keep those values throughout the next conversion until its `done_o`. After reset they read 0.
- R9: `mode_i` is sampled only together with an accepted `start_i`. Changing it during a conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a conversion when idle |
| mode_i | input | 2 | 0 equal slope, 1 companding, 2/3 single-slope |
| cmp_i | input | NCOL | Comparator output per column |
| rd_col_i | input | $clog2(NCOL) | Column chosen for readout |
| count_o | output | STORE_W | Shared counter value for the ramps |
| phase_coarse_o | output | 1 | Coarse pass active |
| phase_fine_o | output | 1 | Fine (or single-slope) pass active |
| force_zero_o | output | 1 | Ramp address forced to 0 |
| busy_o | output | 1 | A conversion is running |
| done_o | output | 1 | One-cycle pulse after a conversion ends |
| ramp_sel_o | output | NCOL*3 | Ramp address per column |
| rd_coarse_o | output | 3 | Read bank coarse code of chosen column |
| rd_fine_o | output | STORE_W | Read bank fine code of chosen column |

## Verification
The hardest case to reach from the ports is a comparator that stays high across the change from the coarse to the fine pass. Since no rising edge is seen in the fine pass, the column must store full scale even though it was high from the first fine count. The stimulus creates this case on purpose: a column trips on the last coarse count and is given a fine trip point of zero. Other columns pulse low for one cycle after tripping, which tests that repeat edges are ignored. A start pulse and a mode change are also applied in the middle of a fine pass, and the running conversion and the held read bank must both be unaffected.

// File: rtl/mramp_pkg.sv
// Shared types for the multiple-ramp conversion sequencer.
// Assumes: mode bit 1 selects single-slope, bit 0 selects companding.
package mramp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2
    } seq_state_t;

    localparam int MODE_SINGLE_BIT = 1;
    localparam int MODE_COMP_BIT   = 0;
endpackage

// File: rtl/mramp_ctrl.sv
// Phase sequencer: owns the shared counter, the phase state and the done pulse.
// Assumes: start_i is only acted on in idle; mode_i is captured with it.
module mramp_ctrl
    import mramp_pkg::*;
#(
    parameter int NRAMP   = 8,
    parameter int FINE_W  = 8,
    parameter int STORE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         mode_i,
    output logic [STORE_W-1:0] cnt_o,
    output logic               in_coarse_o,
    output logic               in_fine_o,
    output logic               force_o,
    output logic               done_o,
    output logic               arm_coarse_o,
    output logic               arm_fine_o,
    output logic               arm_single_o,
    output logic               commit_o
);
    localparam int CNT_W = STORE_W;
    localparam logic [CNT_W-1:0] COARSE_LAST = CNT_W'(NRAMP - 1);
    localparam logic [CNT_W-1:0] EQ_LAST     = CNT_W'(2 ** (FINE_W - 1) - 1);
    localparam logic [CNT_W-1:0] COMP_LAST   = CNT_W'(2 ** (FINE_W - 2) - 1);
    localparam logic [CNT_W-1:0] SS_LAST     = CNT_W'(2 ** STORE_W - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       mode_q;
    logic             done_q;
    logic [CNT_W-1:0] fine_last;
    logic             accept;
    logic             coarse_end;

    // Pick the last fine count from the captured mode.
    always_comb begin
        if (mode_q[MODE_SINGLE_BIT])    fine_last = SS_LAST;
        else if (mode_q[MODE_COMP_BIT]) fine_last = COMP_LAST;
        else                            fine_last = EQ_LAST;
    end

    assign accept     = (state_q == ST_IDLE) && start_i;
    assign coarse_end = (state_q == ST_COARSE) && (cnt_q == COARSE_LAST);
    assign commit_o   = (state_q == ST_FINE) && (cnt_q == fine_last);

    // Phase state, counter, mode capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q  <= mode_i;
                        cnt_q   <= '0;
                        state_q <= mode_i[MODE_SINGLE_BIT] ? ST_FINE : ST_COARSE;
                    end
                end
                ST_COARSE: begin
                    if (coarse_end) begin
                        cnt_q   <= '0;
                        state_q <= ST_FINE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FINE: begin
                    if (commit_o) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cnt_o        = cnt_q;
    assign in_coarse_o  = (state_q == ST_COARSE);
    assign in_fine_o    = (state_q == ST_FINE);
    assign force_o      = in_coarse_o || (in_fine_o && mode_q[MODE_SINGLE_BIT]);
    assign done_o       = done_q;
    assign arm_coarse_o = accept && !mode_i[MODE_SINGLE_BIT];
    assign arm_fine_o   = (accept && mode_i[MODE_SINGLE_BIT]) || coarse_end;
    assign arm_single_o = (state_q == ST_IDLE) ? mode_i[MODE_SINGLE_BIT]
                                               : mode_q[MODE_SINGLE_BIT];
endmodule

// File: rtl/mramp_col.sv
// One column: edge detect on its comparator, first-edge capture per pass,
// and the ramp address it presents. Assumes arm pulses precede each pass.
module mramp_col #(
    parameter int SEL_W   = 3,
    parameter int FINE_W  = 8,
    parameter int STORE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_i,
    input  logic               arm_coarse_i,
    input  logic               arm_fine_i,
    input  logic               arm_single_i,
    input  logic               in_coarse_i,
    input  logic               in_fine_i,
    input  logic               force_i,
    input  logic [STORE_W-1:0] cnt_i,
    output logic [SEL_W-1:0]   coarse_o,
    output logic [STORE_W-1:0] fine_next_o,
    output logic [SEL_W-1:0]   ramp_sel_o
);
    localparam logic [STORE_W-1:0] FINE_FULL =
        {{(STORE_W - FINE_W){1'b0}}, {FINE_W{1'b1}}};

    logic               cmp_q;
    logic               rise;
    logic [SEL_W-1:0]   coarse_q;
    logic               coarse_hit_q;
    logic [STORE_W-1:0] fine_q;
    logic               fine_hit_q;
    logic               fine_take;

    assign rise      = cmp_i && !cmp_q;
    assign fine_take = in_fine_i && rise && !fine_hit_q;

    // Previous comparator level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= cmp_i;
    end

    // Coarse code: preset to full scale, take the first edge in the pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q     <= '0;
            coarse_hit_q <= 1'b0;
        end else if (arm_coarse_i) begin
            coarse_q     <= '1;
            coarse_hit_q <= 1'b0;
        end else if (arm_fine_i && arm_single_i) begin
            coarse_q     <= '0;
            coarse_hit_q <= 1'b1;
        end else if (in_coarse_i && rise && !coarse_hit_q) begin
            coarse_q     <= cnt_i[SEL_W-1:0];
            coarse_hit_q <= 1'b1;
        end
    end

    // Fine code: preset to the full scale of the pass, take the first edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_q     <= '0;
            fine_hit_q <= 1'b0;
        end else if (arm_fine_i) begin
            fine_q     <= arm_single_i ? '1 : FINE_FULL;
            fine_hit_q <= 1'b0;
        end else if (fine_take) begin
            fine_q     <= cnt_i;
            fine_hit_q <= 1'b1;
        end
    end

    assign coarse_o    = coarse_q;
    assign fine_next_o = fine_take ? cnt_i : fine_q;
    assign ramp_sel_o  = force_i ? '0 : coarse_q;
endmodule

// File: rtl/mramp_bank.sv
// Two result banks: one is written on commit, the other is read.
// Assumes commit_i is a single-cycle pulse; the pointer flips with it.
module mramp_bank #(
    parameter int NCOL    = 4,
    parameter int SEL_W   = 3,
    parameter int STORE_W = 10,
    parameter int COL_W   = $clog2(NCOL)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [NCOL*SEL_W-1:0]   coarse_i,
    input  logic [NCOL*STORE_W-1:0] fine_i,
    input  logic [COL_W-1:0]        rd_col_i,
    output logic [SEL_W-1:0]        rd_coarse_o,
    output logic [STORE_W-1:0]      rd_fine_o
);
    logic [SEL_W-1:0]   co_mem [2][NCOL];
    logic [STORE_W-1:0] fi_mem [2][NCOL];
    logic               wr_q;

    // Write the active bank on commit and hand it to the reader.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                for (int c = 0; c < NCOL; c++) begin
                    co_mem[b][c] <= '0;
                    fi_mem[b][c] <= '0;
                end
            end
        end else if (commit_i) begin
            wr_q <= !wr_q;
            for (int c = 0; c < NCOL; c++) begin
                co_mem[wr_q][c] <= coarse_i[c*SEL_W +: SEL_W];
                fi_mem[wr_q][c] <= fine_i[c*STORE_W +: STORE_W];
            end
        end
    end

    // Read port on the bank not being written.
    always_comb begin
        rd_coarse_o = co_mem[!wr_q][rd_col_i];
        rd_fine_o   = fi_mem[!wr_q][rd_col_i];
    end
endmodule

// File: rtl/mramp_seq.sv
// Top: multiple-ramp column conversion sequencer with NCOL columns.
// Assumes NRAMP is a power of two and comparators are synchronous to clk.
module mramp_seq #(
    parameter int  NCOL    = 4,
    parameter int  NRAMP   = 8,
    parameter int  FINE_W  = 8,
    parameter int  STORE_W = 10,
    localparam int SEL_W   = $clog2(NRAMP),
    localparam int COL_W   = $clog2(NCOL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [1:0]            mode_i,
    input  logic [NCOL-1:0]       cmp_i,
    input  logic [COL_W-1:0]      rd_col_i,
    output logic [STORE_W-1:0]    count_o,
    output logic                  phase_coarse_o,
    output logic                  phase_fine_o,
    output logic                  force_zero_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [NCOL*SEL_W-1:0] ramp_sel_o,
    output logic [SEL_W-1:0]      rd_coarse_o,
    output logic [STORE_W-1:0]    rd_fine_o
);
    logic                    arm_coarse;
    logic                    arm_fine;
    logic                    arm_single;
    logic                    commit;
    logic [NCOL*SEL_W-1:0]   coarse_all;
    logic [NCOL*STORE_W-1:0] fine_all;

    mramp_ctrl #(.NRAMP(NRAMP), .FINE_W(FINE_W), .STORE_W(STORE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .cnt_o        (count_o),
        .in_coarse_o  (phase_coarse_o),
        .in_fine_o    (phase_fine_o),
        .force_o      (force_zero_o),
        .done_o       (done_o),
        .arm_coarse_o (arm_coarse),
        .arm_fine_o   (arm_fine),
        .arm_single_o (arm_single),
        .commit_o     (commit)
    );

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        mramp_col #(.SEL_W(SEL_W), .FINE_W(FINE_W), .STORE_W(STORE_W)) u_col (
            .clk          (clk),
            .rst_n        (rst_n),
            .cmp_i        (cmp_i[c]),
            .arm_coarse_i (arm_coarse),
            .arm_fine_i   (arm_fine),
            .arm_single_i (arm_single),
            .in_coarse_i  (phase_coarse_o),
            .in_fine_i    (phase_fine_o),
            .force_i      (force_zero_o),
            .cnt_i        (count_o),
            .coarse_o     (coarse_all[c*SEL_W +: SEL_W]),
            .fine_next_o  (fine_all[c*STORE_W +: STORE_W]),
            .ramp_sel_o   (ramp_sel_o[c*SEL_W +: SEL_W])
        );
    end

    mramp_bank #(.NCOL(NCOL), .SEL_W(SEL_W), .STORE_W(STORE_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit),
        .coarse_i    (coarse_all),
        .fine_i      (fine_all),
        .rd_col_i    (rd_col_i),
        .rd_coarse_o (rd_coarse_o),
        .rd_fine_o   (rd_fine_o)
    );

    assign busy_o = phase_coarse_o || phase_fine_o;
endmodule

// File: rtl/mramp_seq_chk.sv
// Checker bound to mramp_seq: temporal rules on its ports.
module mramp_seq_chk #(
    parameter int NCOL    = 4,
    parameter int NRAMP   = 8,
    parameter int FINE_W  = 8,
    parameter int STORE_W = 10,
    parameter int SEL_W   = 3,
    parameter int COL_W   = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [COL_W-1:0]      rd_col_i,
    input logic [STORE_W-1:0]    count_o,
    input logic                  phase_coarse_o,
    input logic                  phase_fine_o,
    input logic                  force_zero_o,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [NCOL*SEL_W-1:0] ramp_sel_o,
    input logic [SEL_W-1:0]      rd_coarse_o,
    input logic [STORE_W-1:0]    rd_fine_o
);
    AST_COARSE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_coarse_o |-> (int'(count_o) < NRAMP)); // R1
    AST_COARSE_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_coarse_o && $past(phase_coarse_o)) |-> (int'(count_o) == int'($past(count_o)) + 1)); // R1
    AST_FORCE_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero_o |-> (ramp_sel_o == '0)); // R2
    AST_COARSE_THEN_FINE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_coarse_o) |-> (phase_fine_o && count_o == '0)); // R4
    AST_SEL_HOLD_FINE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_fine_o && $past(phase_fine_o) && !force_zero_o) |-> $stable(ramp_sel_o)); // R4
    AST_FINE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_fine_o && !force_zero_o) |-> (int'(count_o) < 2 ** (FINE_W - 1))); // R4
    AST_DONE_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(phase_fine_o) && !busy_o)); // R7
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && $stable(rd_col_i)) |-> ($stable(rd_coarse_o) && $stable(rd_fine_o))); // R8
endmodule

bind mramp_seq mramp_seq_chk #(
    .NCOL(NCOL), .NRAMP(NRAMP), .FINE_W(FINE_W), .STORE_W(STORE_W),
    .SEL_W(SEL_W), .COL_W(COL_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_col_i       (rd_col_i),
    .count_o        (count_o),
    .phase_coarse_o (phase_coarse_o),
    .phase_fine_o   (phase_fine_o),
    .force_zero_o   (force_zero_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .ramp_sel_o     (ramp_sel_o),
    .rd_coarse_o    (rd_coarse_o),
    .rd_fine_o      (rd_fine_o)
);

// File: tb/sim_mramp_seq.sv
// Bench for mramp_seq: behavioural cycle model compared on every negedge,
// plus directed readout checks after each conversion.
module sim_mramp_seq;
    localparam int NC    = 4;
    localparam int NEVER = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [3:0]  cmp_i = '0;
    logic [1:0]  rd_col_i = '0;
    logic [9:0]  count_o;
    logic        phase_coarse_o, phase_fine_o, force_zero_o, busy_o, done_o;
    logic [11:0] ramp_sel_o;
    logic [2:0]  rd_coarse_o;
    logic [9:0]  rd_fine_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit live     = 1'b0;

    // stimulus pattern per column
    int ct [NC];
    int ft [NC];
    bit gl [NC];

    // behavioural model
    int m_state = 0;   // 0 idle, 1 coarse, 2 fine
    int m_cnt = 0, m_mode = 0, m_wr = 0;
    bit m_done = 0;
    int m_co [NC], m_fi [NC];
    bit m_hc [NC], m_hf [NC], m_prev [NC];
    int m_bco [2][NC], m_bfi [2][NC];

    mramp_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .cmp_i(cmp_i), .rd_col_i(rd_col_i), .count_o(count_o),
        .phase_coarse_o(phase_coarse_o), .phase_fine_o(phase_fine_o),
        .force_zero_o(force_zero_o), .busy_o(busy_o), .done_o(done_o),
        .ramp_sel_o(ramp_sel_o), .rd_coarse_o(rd_coarse_o), .rd_fine_o(rd_fine_o)
    );

    always #4 clk = !clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_mode = 0; m_wr = 0; m_done = 0;
            for (int c = 0; c < NC; c++) begin
                m_co[c] = 0; m_fi[c] = 0; m_hc[c] = 0; m_hf[c] = 0; m_prev[c] = 0;
                m_bco[0][c] = 0; m_bco[1][c] = 0; m_bfi[0][c] = 0; m_bfi[1][c] = 0;
            end
            live = 1'b1;
        end else begin
            bit edge_seen [NC];
            int flen;
            for (int c = 0; c < NC; c++) edge_seen[c] = cmp_i[c] && !m_prev[c];
            m_done = 0;
            flen = (m_mode >= 2) ? 1024 : ((m_mode == 1) ? 64 : 128);
            if (m_state == 0) begin
                if (start_i) begin
                    m_mode = mode_i; m_cnt = 0;
                    for (int c = 0; c < NC; c++) begin
                        if (m_mode >= 2) begin m_co[c] = 0; m_fi[c] = 1023; m_hf[c] = 0; end
                        else begin m_co[c] = 7; m_hc[c] = 0; end
                    end
                    m_state = (m_mode >= 2) ? 2 : 1;
                end
            end else if (m_state == 1) begin
                for (int c = 0; c < NC; c++)
                    if (edge_seen[c] && !m_hc[c]) begin m_co[c] = m_cnt; m_hc[c] = 1; end
                if (m_cnt == 7) begin
                    m_state = 2; m_cnt = 0;
                    for (int c = 0; c < NC; c++) begin m_fi[c] = 255; m_hf[c] = 0; end
                end else m_cnt++;
            end else begin
                for (int c = 0; c < NC; c++)
                    if (edge_seen[c] && !m_hf[c]) begin m_fi[c] = m_cnt; m_hf[c] = 1; end
                if (m_cnt == flen - 1) begin
                    for (int c = 0; c < NC; c++) begin
                        m_bco[m_wr][c] = m_co[c]; m_bfi[m_wr][c] = m_fi[c];
                    end
                    m_wr ^= 1; m_state = 0; m_cnt = 0; m_done = 1;
                end else m_cnt++;
            end
            for (int c = 0; c < NC; c++) m_prev[c] = cmp_i[c];
        end
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // Compare on each falling edge, then drive comparators for the next edge.
    always @(negedge clk) begin
        if (live) begin
            bit frc;
            frc = (m_state == 1) || (m_state == 2 && m_mode >= 2);
            check("R1", "count_o", int'(count_o), m_cnt);
            check("R1", "phase_coarse_o", int'(phase_coarse_o), int'(m_state == 1));
            check("R4", "phase_fine_o", int'(phase_fine_o), int'(m_state == 2));
            check("R2", "force_zero_o", int'(force_zero_o), int'(frc));
            check("R7", "busy_o", int'(busy_o), int'(m_state != 0));
            check("R7", "done_o", int'(done_o), int'(m_done));
            for (int c = 0; c < NC; c++)
                check("R4", "ramp_sel field", int'(ramp_sel_o[c*3 +: 3]), frc ? 0 : m_co[c]);
            check("R8", "rd_coarse_o", int'(rd_coarse_o), m_bco[m_wr ^ 1][rd_col_i]);
            check("R8", "rd_fine_o", int'(rd_fine_o), m_bfi[m_wr ^ 1][rd_col_i]);
        end
        for (int c = 0; c < NC; c++) begin
            int trip;
            if (m_state == 0) cmp_i[c] <= 1'b0;
            else begin
                trip = (m_state == 1) ? ct[c] : ft[c];
                cmp_i[c] <= (m_cnt >= trip) && !(gl[c] && m_cnt == trip + 1);
            end
        end
    end

    // Run one conversion; optionally disturb start_i/mode_i mid-pass (R1, R9).
    task automatic convert(input int mode, input bit disturb);
        @(negedge clk); #1;
        mode_i = 2'(mode); start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        if (disturb) begin
            repeat (20) @(negedge clk);
            #1 start_i = 1'b1; mode_i = 2'd2;
            @(negedge clk); #1 start_i = 1'b0; mode_i = 2'd0;
        end
        while (!done_o) @(negedge clk);
        check("R7", "done_o pulse seen", int'(done_o), 1);
    endtask

    // Read every column and compare with hand-worked expectations.
    task automatic read_all(input string req, input int eco [NC], input int efi [NC]);
        for (int c = 0; c < NC; c++) begin
            @(negedge clk); #1 rd_col_i = 2'(c);
            #2;
            check(req, "read coarse", int'(rd_coarse_o), eco[c]);
            check(req, "read fine", int'(rd_fine_o), efi[c]);
        end
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin ct[c] = NEVER; ft[c] = NEVER; gl[c] = 0; end
        repeat (3) @(negedge clk);
        // R7 R8: reset state
        check("R7", "reset busy_o", int'(busy_o), 0);
        check("R8", "reset rd_fine_o", int'(rd_fine_o), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R5: equal slope, a glitching column, a column that never trips
        ct = '{2, 5, 0, NEVER};  ft = '{10, 100, 127, NEVER};  gl = '{0, 1, 0, 0};
        convert(0, 1'b0);
        read_all("R3", '{2, 5, 0, 7}, '{10, 100, 127, 255});

        // R4 R9: companding; column 0 stays high across the pass change -> 255;
        // a start and mode change mid-pass are ignored
        ct = '{7, 3, 6, 1};  ft = '{0, 63, 30, 64};  gl = '{0, 0, 1, 0};
        convert(1, 1'b1);
        read_all("R5", '{7, 3, 6, 1}, '{255, 63, 30, 255});

        // R6: single-slope pass, coarse code 0, untripped column reads 1023
        ct = '{NEVER, NEVER, NEVER, NEVER};  ft = '{1000, 1023, 5, NEVER};  gl = '{0, 0, 1, 0};
        convert(2, 1'b0);
        read_all("R6", '{0, 0, 0, 0}, '{1000, 1023, 5, 1023});

        // R8: during the next conversion the read bank keeps the last results
        ct = '{1, 1, 1, 1};  ft = '{3, 3, 3, 3};  gl = '{0, 0, 0, 0};
        @(negedge clk); #1 rd_col_i = 2'd1; mode_i = 2'd0; start_i = 1'b1;
        @(negedge clk); #1 start_i = 1'b0;
        repeat (30) @(negedge clk);
        #2 check("R8", "held fine during conversion", int'(rd_fine_o), 1023);
        while (!done_o) @(negedge clk);
        #2 check("R8", "new fine after done", int'(rd_fine_o), 3);

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule